// File: doc/BRIEF.md
# Phase-Correct PWM Timer with Glitch-Free Compare Update

This block is an 8-bit triangle counter. It produces a symmetric, centre-aligned PWM waveform. The counter steps once on each cycle where the prescaled tick enable is high. It climbs from 0x00 to 0xFF and then falls back to 0x00, so one PWM period takes 510 ticks. The output pin toggles whenever the count meets the active compare value. The direction of travel at that moment decides whether the pin is cleared or set.

Software writes the compare value into a holding buffer. That buffer moves into the active compare register only when the count arrives at 0xFF. A new duty cycle therefore never cuts a pulse short in the middle of a period. Two flags mark events. The wrap flag sets as the count leaves 0x00. The match flag sets when the count arrives at the active compare value. Each flag can raise the interrupt request, gated by its own enable and by a global enable.

Top module: `pwm_pc_timer`

## Requirements
- R1: On every tick the counter moves by one. It counts up to 0xFF, turns, counts down to 0x00 and turns again, so the sequence repeats every 510 ticks. Without a tick the counter holds its value. Reset leaves it at 0x00, heading up. The count reads back at register address 2.
- R2: A write to register address 0 stores the value in the holding buffer. A read of address 0 returns the holding buffer, so it always shows the most recent write.
- R3: The holding buffer is copied into the active compare register on the tick that brings the count to 0xFF, and at no other time. A write made between two such ticks leaves the output waveform unchanged until the next copy.
- R4: With output mode 2'b10 and an active value C in the range 1 to 254, the pin behaves as follows. After an upward step it is high exactly when count < C. After a downward step it is high exactly when count <= C.
- R5: With output mode 2'b11, the pin is the complement of the R4 waveform.
- R6: An active value of 0x00 forces a constant level, and so does 0xFF. In mode 2'b10, 0x00 gives low and 0xFF gives high; mode 2'b11 gives the opposite levels. The level applies in the same cycle that the active register takes the value.
- R7: With output mode 2'b00 or 2'b01 the pin stays low.
- R8: The wrap flag sets on a tick taken while the count is 0x00.
- R9: The match flag sets on a tick after which the count equals the active compare value, the value used being the one copied on that same tick.
- R10: The flags read back at register address 1, with the wrap flag in bit 0 and the match flag in bit 1. Writing a one to a bit at address 1 clears that flag. A flag event in the same cycle wins over the clear.
- R11: The interrupt request equals the global enable ANDed with the OR of (wrap flag AND wrap enable) and (match flag AND match enable).
- R12: While reset is held, the pin, both flags, the interrupt request, the holding buffer and the count all read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled timer tick; the counter steps on cycles where it is high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 compare buffer, 1 flags, 2 count, 3 reads zero |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| out_mode | input | 2 | Output mode: 00/01 off, 10 non-inverting, 11 inverting |
| ovf_ie | input | 1 | Wrap interrupt enable |
| cmp_ie | input | 1 | Match interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| pwm_o | output | 1 | PWM output pin |
| ovf_flag_o | output | 1 | Wrap flag |
| cmp_flag_o | output | 1 | Match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The pin is compared against an arithmetic model on every tick. The sweep covers eleven compare values in each of the four output modes. The values include both extremes, their neighbours (1, 2, 253, 254) and mid-scale points (127, 128). Together these separate an off-by-one in the up-slope from one in the down-slope, and they separate forced levels from real compare matches. A run with gaps in the tick stream checks that the count holds between ticks. Separate sequences write a new compare value in mid-period to show that the old duty survives until the top. They also clear a flag in the same cycle as its event to show which of the two wins.

// File: rtl/pwm_pc_pkg.sv
package pwm_pc_pkg;

    typedef enum logic [1:0] {
        OUT_OFF     = 2'b00,
        OUT_OFF_ALT = 2'b01,
        OUT_NONINV  = 2'b10,
        OUT_INV     = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        ADDR_CMP  = 2'b00,
        ADDR_FLAG = 2'b01,
        ADDR_CNT  = 2'b10,
        ADDR_NONE = 2'b11
    } reg_addr_e;

    typedef struct packed {
        logic cmp;
        logic ovf;
    } flag_t;

endpackage

// File: rtl/pwm_pc_counter.sv
module pwm_pc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_next_o,
    output logic         step_up_o,
    output logic         top_evt_o,
    output logic         leave_bot_o
);
    localparam logic [W-1:0] CNT_TOP = '1;
    localparam logic [W-1:0] CNT_BOT = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        nxt  = st_q.cnt;
        if (tick) begin
            nxt      = st_q.up ? (st_q.cnt + 1'b1) : (st_q.cnt - 1'b1);
            st_d.cnt = nxt;
            if (nxt == CNT_TOP) begin
                st_d.up = 1'b0;
            end else if (nxt == CNT_BOT) begin
                st_d.up = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_BOT;
            st_q.up  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign cnt_next_o  = nxt;
    assign step_up_o   = st_q.up;
    assign top_evt_o   = tick && (nxt == CNT_TOP);
    assign leave_bot_o = tick && (st_q.cnt == CNT_BOT);

endmodule

// File: rtl/pwm_pc_cmpbuf.sv
module pwm_pc_cmpbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         latch,
    output logic [W-1:0] buf_o,
    output logic [W-1:0] act_o,
    output logic [W-1:0] act_next_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] active;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.hold = wdata;
        end
        if (latch) begin
            st_d.active = st_q.hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_o      = st_q.hold;
    assign act_o      = st_q.active;
    assign act_next_o = st_d.active;

endmodule

// File: rtl/pwm_pc_wavegen.sv
module pwm_pc_wavegen
    import pwm_pc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt_next,
    input  logic         step_up,
    input  logic [W-1:0] act_next,
    input  logic [W-1:0] act_q,
    input  logic [1:0]   mode,
    output logic         pwm_o,
    output logic         match_evt_o
);
    localparam logic [W-1:0] CNT_TOP = '1;
    localparam logic [W-1:0] CNT_BOT = '0;

    typedef struct packed {
        logic wave;
    } wave_st_t;

    wave_st_t st_d, st_q;
    logic     level;
    logic     forced_hi;
    logic     forced_lo;

    // wave is kept in non-inverting polarity; it is pinned low at the top
    // and high at the bottom so a newly latched value starts from a clean state
    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (cnt_next == CNT_TOP) begin
                st_d.wave = 1'b0;
            end else if (cnt_next == CNT_BOT) begin
                st_d.wave = 1'b1;
            end else if (cnt_next == act_next) begin
                st_d.wave = !step_up;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wave <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        forced_hi = (act_q == CNT_TOP);
        forced_lo = (act_q == CNT_BOT);
        if (forced_hi) begin
            level = 1'b1;
        end else if (forced_lo) begin
            level = 1'b0;
        end else begin
            level = st_q.wave;
        end
        unique case (out_mode_e'(mode))
            OUT_NONINV: pwm_o = level;
            OUT_INV:    pwm_o = !level;
            default:    pwm_o = 1'b0;
        endcase
    end

    assign match_evt_o = tick && (cnt_next == act_next);

endmodule

// File: rtl/pwm_pc_flags.sv
module pwm_pc_flags
    import pwm_pc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ovf_evt,
    input  logic  cmp_evt,
    input  logic  clr_en,
    input  flag_t clr_bits,
    input  logic  ovf_ie,
    input  logic  cmp_ie,
    input  logic  glb_ie,
    output flag_t flags_o,
    output logic  irq_o
);
    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en && clr_bits.ovf) begin
            st_d.ovf = 1'b0;
        end
        if (clr_en && clr_bits.cmp) begin
            st_d.cmp = 1'b0;
        end
        if (ovf_evt) begin
            st_d.ovf = 1'b1;
        end
        if (cmp_evt) begin
            st_d.cmp = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q;
    assign irq_o   = glb_ie && ((st_q.ovf && ovf_ie) || (st_q.cmp && cmp_ie));

endmodule

// File: rtl/pwm_pc_timer.sv
module pwm_pc_timer
    import pwm_pc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic [1:0]   out_mode,
    input  logic         ovf_ie,
    input  logic         cmp_ie,
    input  logic         glb_ie,
    output logic         pwm_o,
    output logic         ovf_flag_o,
    output logic         cmp_flag_o,
    output logic         irq_o
);
    localparam int FLAG_PAD = W - 2;

    logic [W-1:0] cnt_w;
    logic [W-1:0] cnt_next_w;
    logic         step_up_w;
    logic         top_evt_w;
    logic         leave_bot_w;
    logic [W-1:0] cmp_buf_w;
    logic [W-1:0] cmp_act_w;
    logic [W-1:0] cmp_act_next_w;
    logic         match_evt_w;
    logic         wr_cmp;
    logic         wr_flag;
    flag_t        flags_w;
    flag_t        clr_bits_w;

    assign wr_cmp  = reg_wr && (reg_addr_e'(reg_addr) == ADDR_CMP);
    assign wr_flag = reg_wr && (reg_addr_e'(reg_addr) == ADDR_FLAG);
    assign clr_bits_w.ovf = reg_wdata[0];
    assign clr_bits_w.cmp = reg_wdata[1];

    pwm_pc_counter #(.W(W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_en),
        .cnt_o       (cnt_w),
        .cnt_next_o  (cnt_next_w),
        .step_up_o   (step_up_w),
        .top_evt_o   (top_evt_w),
        .leave_bot_o (leave_bot_w)
    );

    pwm_pc_cmpbuf #(.W(W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_cmp),
        .wdata      (reg_wdata),
        .latch      (top_evt_w),
        .buf_o      (cmp_buf_w),
        .act_o      (cmp_act_w),
        .act_next_o (cmp_act_next_w)
    );

    pwm_pc_wavegen #(.W(W)) u_wave (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_en),
        .cnt_next    (cnt_next_w),
        .step_up     (step_up_w),
        .act_next    (cmp_act_next_w),
        .act_q       (cmp_act_w),
        .mode        (out_mode),
        .pwm_o       (pwm_o),
        .match_evt_o (match_evt_w)
    );

    pwm_pc_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_evt  (leave_bot_w),
        .cmp_evt  (match_evt_w),
        .clr_en   (wr_flag),
        .clr_bits (clr_bits_w),
        .ovf_ie   (ovf_ie),
        .cmp_ie   (cmp_ie),
        .glb_ie   (glb_ie),
        .flags_o  (flags_w),
        .irq_o    (irq_o)
    );

    assign ovf_flag_o = flags_w.ovf;
    assign cmp_flag_o = flags_w.cmp;

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            ADDR_CMP:  reg_rdata = cmp_buf_w;
            ADDR_FLAG: reg_rdata = {{FLAG_PAD{1'b0}}, flags_w.cmp, flags_w.ovf};
            ADDR_CNT:  reg_rdata = cnt_w;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_pc_timer_chk.sv
module pwm_pc_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [W-1:0] buffer,
    input logic [W-1:0] active,
    input logic [1:0]   mode,
    input logic         pwm,
    input logic         irq,
    input logic         glb_ie
);
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((W'(cnt - $past(cnt)) == ONE) || (W'($past(cnt) - cnt) == ONE)));

    p_latch_only_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> (cnt == ALL1));

    p_latch_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == ALL1) && ($past(cnt) != ALL1)) |-> (active == $past(buffer)));

    p_force_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((active == ALL1) && (mode == 2'b10)) |-> pwm);

    p_force_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((active == '0) && (mode == 2'b10)) |-> !pwm);

    p_mode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> !pwm);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_ie |-> !irq);

endmodule

bind pwm_pc_timer pwm_pc_timer_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_en),
    .cnt    (cnt_w),
    .buffer (cmp_buf_w),
    .active (cmp_act_w),
    .mode   (out_mode),
    .pwm    (pwm_o),
    .irq    (irq_o),
    .glb_ie (glb_ie)
);

// File: tb/pwm_pc_timer_tb.sv
`timescale 1ns/1ps
module pwm_pc_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd2;
    logic [7:0] reg_wdata = 8'd0;
    wire  [7:0] reg_rdata;
    logic [1:0] out_mode = 2'b10;
    logic       ovf_ie = 1'b0;
    logic       cmp_ie = 1'b0;
    logic       glb_ie = 1'b0;
    wire        pwm_o, ovf_flag_o, cmp_flag_o, irq_o;

    pwm_pc_timer #(.W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_mode(out_mode), .ovf_ie(ovf_ie), .cmp_ie(cmp_ie), .glb_ie(glb_ie),
        .pwm_o(pwm_o), .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    int mcnt, mbuf, mact;
    bit mdir_up, mlast_up, mov, mcf;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mcnt = 0; mdir_up = 1; mlast_up = 1; mbuf = 0; mact = 0; mov = 0; mcf = 0;
    endtask

    task automatic model_tick(bit t, bit w, int a, int d);
        bit ovf_ev, cmp_ev;
        ovf_ev = 0;
        cmp_ev = 0;
        if (t) begin
            ovf_ev   = (mcnt == 0);
            mlast_up = mdir_up;
            mcnt     = mdir_up ? mcnt + 1 : mcnt - 1;
            if (mcnt == 255) begin
                mdir_up = 0;
                mact    = mbuf;
            end
            if (mcnt == 0) mdir_up = 1;
            cmp_ev = (mcnt == mact);
        end
        if (w && a == 0) mbuf = d;
        if (ovf_ev) mov = 1; else if (w && a == 1 && d[0]) mov = 0;
        if (cmp_ev) mcf = 1; else if (w && a == 1 && d[1]) mcf = 0;
    endtask

    function automatic logic exp_pwm();
        logic n;
        if (mact == 255) n = 1'b1;
        else if (mact == 0) n = 1'b0;
        else n = mlast_up ? (mcnt < mact) : (mcnt <= mact);
        if (!out_mode[1]) return 1'b0;
        return out_mode[0] ? !n : n;
    endfunction

    function automatic logic exp_irq();
        return glb_ie && ((mov && ovf_ie) || (mcf && cmp_ie));
    endfunction

    function automatic string pwm_tag();
        if (!out_mode[1]) return "R7";
        if (mact == 0 || mact == 255) return "R6";
        if (out_mode[0]) return "R5";
        return "R4";
    endfunction

    // called at a negative edge; returns at the following negative edge
    task automatic cyc(bit t, bit w, int a, int d);
        tick_en = t;
        reg_wr  = w;
        if (w) begin
            reg_addr  = 2'(a);
            reg_wdata = 8'(d);
        end
        @(posedge clk);
        model_tick(t, w, a, d);
        @(negedge clk);
        tick_en  = 0;
        reg_wr   = 0;
        reg_addr = 2'd2;
        #1;
    endtask

    task automatic rd(int a, string req, int exp);
        reg_addr = 2'(a);
        #1;
        chk(req, reg_rdata, exp);
        reg_addr = 2'd2;
        #1;
    endtask

    task automatic check_all(string tag);
        chk("R1", reg_rdata, mcnt);
        chk(tag, pwm_o, exp_pwm());
        chk("R8", ovf_flag_o, mov);
        chk("R9", cmp_flag_o, mcf);
        chk("R11", irq_o, exp_irq());
    endtask

    task automatic run(int n, int gap);
        for (int i = 0; i < n; i++) begin
            cyc((gap == 0) ? 1'b1 : ((i % gap) != 0), 0, 0, 0);
            check_all(pwm_tag());
        end
    endtask

    task automatic set_cmp(int c);
        cyc(0, 1, 0, c);
        rd(0, "R2", c);
        while (mact != c) begin
            cyc(1, 0, 0, 0);
            check_all(pwm_tag());
        end
    endtask

    initial begin
        #750000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int vals[11] = '{0, 1, 2, 3, 127, 128, 200, 253, 254, 255, 100};
        model_reset();
        glb_ie = 1; ovf_ie = 1; cmp_ie = 1;
        repeat (3) @(negedge clk);
        #1;
        // R12: reset state
        chk("R12", pwm_o, 0);
        chk("R12", ovf_flag_o, 0);
        chk("R12", cmp_flag_o, 0);
        chk("R12", irq_o, 0);
        rd(0, "R12", 0);
        rd(2, "R12", 0);
        rst_n = 1;
        @(negedge clk);
        #1;
        glb_ie = 0;

        // R1: gapped ticks, counter holds between ticks, covers a full turn
        run(900, 3);
        run(520, 0);

        // sweep of compare values over all output modes
        for (int m = 0; m < 4; m++) begin
            out_mode = 2'(m ^ 2);
            glb_ie = m[0];
            ovf_ie = m[1];
            cmp_ie = !m[1];
            foreach (vals[k]) begin
                set_cmp(vals[k]);
                run(510, 0);
            end
        end

        // R3: mid-period write must not disturb the current period
        out_mode = 2'b10;
        set_cmp(100);
        while (!(mcnt == 150 && mdir_up)) begin
            cyc(1, 0, 0, 0);
            check_all(pwm_tag());
        end
        cyc(1, 1, 0, 200);
        rd(0, "R2", 200);
        while (mact != 200) begin
            chk("R3", pwm_o, 0);
            chk("R3", pwm_o, exp_pwm());
            cyc(1, 0, 0, 0);
        end
        chk("R3", reg_rdata, 255);
        run(510, 0);

        // R10: write-one-to-clear and event priority
        chk("R10", {ovf_flag_o, cmp_flag_o}, 2'b11);
        cyc(0, 1, 1, 1);
        rd(1, "R10", 2);
        cyc(0, 1, 1, 2);
        rd(1, "R10", 0);
        while (mcnt != 0) cyc(1, 0, 0, 0);
        cyc(1, 1, 1, 3);
        chk("R10", ovf_flag_o, 1);
        chk("R10", cmp_flag_o, mcf);
        rd(1, "R10", {mcf, mov});
        cyc(0, 1, 1, 3);
        rd(1, "R10", 0);
        while ((mdir_up ? mcnt + 1 : mcnt - 1) != mact) cyc(1, 0, 0, 0);
        cyc(1, 1, 1, 2);
        chk("R10", cmp_flag_o, 1);
        rd(1, "R10", {1'b1, mov});

        // R11: interrupt gating over all enable combinations
        for (int ph = 0; ph < 2; ph++) begin
            for (int e = 0; e < 8; e++) begin
                glb_ie = e[0]; ovf_ie = e[1]; cmp_ie = e[2];
                #1;
                chk("R11", irq_o, exp_irq());
            end
            cyc(0, 1, 1, 2);
        end
        cyc(0, 1, 1, 3);
        glb_ie = 1; ovf_ie = 1; cmp_ie = 1;
        #1;
        chk("R11", irq_o, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule